// File: doc/BRIEF.md
# Phase Comparator with Lock Detect

This block compares the timing of two strobe trains inside a synthesizer loop and turns the difference into charge-pump controls. The first train is a reference tick. It is divided by a programmable ratio to form the comparison event. The second train is the divided oscillator pulse. Whichever event arrives first opens an error window, and the other event closes it. During the window the block asks the pump to source or sink current. At every other time the pump stays high-impedance.

Everything runs on one system clock, and phase error is measured in whole clock cycles. A small dead zone of `DEAD_CYC` cycles suppresses errors too short to resolve. Errors longer than the dead zone are reproduced at their full width. A polarity input selects which lead direction means "source". An active-low lock indicator mirrors the error window exactly. A bias-select bit is passed to the pump current stage, and an enable input clears the comparator.

Top module: `phase_cmp_ld`

## Requirements
- R1: After reset, the divider produces a comparison event on reference ticks number 1, R+1, 2R+1 and so on, where R is `r_div`. R=0 acts as R=1. The divider keeps counting while `enable` is low.
- R2: Let e be the number of cycles between the comparison event and the oscillator pulse. When |e| > `DEAD_CYC`, exactly one pump control is asserted for exactly |e| consecutive cycles.
- R3: When |e| <= `DEAD_CYC`, including coincident events, neither pump control is asserted, `pump_oe` stays 0 and `lock_n` stays 1.
- R4: With `pol_pos`=1, a leading reference asserts `pump_up` and a leading oscillator pulse asserts `pump_dn`. With `pol_pos`=0 the two are swapped. A single pulse never switches direction.
- R5: `pump_up` and `pump_dn` are never high together. `pump_oe` is 1 exactly when one of them is high; otherwise the pump is tristate.
- R6: `lock_n` is 0 in exactly the cycles in which `pump_oe` is 1, so its low width equals the error width.
- R7: A pump control first goes high `DEAD_CYC`+2 clock edges after the edge that samples the leading strobe.
- R8: While `enable` is low, both flags are cleared and strobes are ignored. The outputs are off from the second edge after `enable` falls.
- R9: `pump_hi` follows `bias_hi` one cycle later (1 = high pump current).
- R10: A second strobe of the leading input, arriving before the lagging input, neither restarts nor shortens the window.
- R11: Reset drives `pump_up`, `pump_dn`, `pump_oe` and `pump_hi` to 0 and `lock_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Comparator enable; low clears both flags |
| ref_tick | input | 1 | One-cycle reference strobe |
| vco_pulse | input | 1 | One-cycle divided oscillator strobe |
| r_div | input | R_W | Reference division ratio |
| pol_pos | input | 1 | 1 selects positive pump polarity |
| bias_hi | input | 1 | 1 selects high pump current |
| pump_up | output | 1 | Source current request |
| pump_dn | output | 1 | Sink current request |
| pump_oe | output | 1 | Pump drive enable; 0 means tristate |
| pump_hi | output | 1 | Registered bias select |
| lock_n | output | 1 | Active-low phase-error indicator |

## Verification
The main sweep runs one isolated event pair for every signed offset from -8 to +8 cycles, under both polarities. It counts the cycles on each pump control and on the lock output. This separates dead-zone suppression from pulses that are merely shortened, and it shows whether a direction is swapped or a pulse is truncated. The same runs measure the onset latency.

The divider is swept over ratios 0 to 5, with eight reference ticks each. The comparator is cleared between ticks, so the ticks that passed the divider can be counted at the lock output. Separate patterns cover these cases:
- a duplicated leading strobe;
- strobes applied while the comparator is disabled;
- disabling in the middle of a window;
- toggling the bias bit.

// File: rtl/phc_pkg.sv
package phc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_REF_AHEAD = 2'd1,
    ST_VCO_AHEAD = 2'd2
  } lead_e;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int R_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_tick,
  input  logic [R_W-1:0] r_div,
  output logic           comp_tick
);
  logic [R_W-1:0] cnt;
  logic [R_W-1:0] reload;

  // A ratio of zero behaves like a ratio of one.
  assign reload = (r_div == '0) ? '0 : r_div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      comp_tick <= 1'b0;
    end else begin
      comp_tick <= 1'b0;
      if (ref_tick) begin
        if (cnt == '0) begin
          comp_tick <= 1'b1;
          cnt       <= reload;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/edge_pair_core.sv
module edge_pair_core
  import phc_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic comp_tick,
  input  logic vco_pulse,
  output logic active,
  output logic ref_ahead
);
  localparam int CNT_W = $clog2(DEAD_CYC + 2);
  localparam logic [CNT_W-1:0] AGE_MAX = CNT_W'(DEAD_CYC + 1);
  localparam logic [CNT_W-1:0] DEAD_V  = CNT_W'(DEAD_CYC);

  lead_e          st;
  logic [CNT_W-1:0] age;
  logic [CNT_W-1:0] tail;
  logic           tail_ref;
  logic           vco_q;
  logic           wait_act;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st       <= ST_IDLE;
      age      <= '0;
      tail     <= '0;
      tail_ref <= 1'b0;
      vco_q    <= 1'b0;
    end else begin
      vco_q <= vco_pulse;
      if (tail != '0) tail <= tail - 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (comp_tick ^ vco_q) begin
            st  <= comp_tick ? ST_REF_AHEAD : ST_VCO_AHEAD;
            age <= CNT_W'(1);
          end
        end
        ST_REF_AHEAD: begin
          if (vco_q) begin
            st  <= ST_IDLE;
            age <= '0;
            if (age > DEAD_V) begin
              tail     <= DEAD_V;
              tail_ref <= 1'b1;
            end
          end else if (age != AGE_MAX) begin
            age <= age + 1'b1;
          end
        end
        ST_VCO_AHEAD: begin
          if (comp_tick) begin
            st  <= ST_IDLE;
            age <= '0;
            if (age > DEAD_V) begin
              tail     <= DEAD_V;
              tail_ref <= 1'b0;
            end
          end else if (age != AGE_MAX) begin
            age <= age + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // The window is emitted DEAD_CYC cycles late. The tail re-creates the
  // cycles hidden by the dead zone once the window is known to exceed it.
  assign wait_act  = (st != ST_IDLE) && (age > DEAD_V);
  assign active    = wait_act || (tail != '0);
  assign ref_ahead = wait_act ? (st == ST_REF_AHEAD) : tail_ref;
endmodule

// File: rtl/pump_drive.sv
module pump_drive (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ref_ahead,
  input  logic pol_pos,
  input  logic bias_hi,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe,
  output logic pump_hi,
  output logic lock_n
);
  logic src, snk;

  assign src = active && (ref_ahead == pol_pos);
  assign snk = active && (ref_ahead != pol_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
      pump_oe <= 1'b0;
      pump_hi <= 1'b0;
      lock_n  <= 1'b1;
    end else begin
      pump_up <= src;
      pump_dn <= snk;
      pump_oe <= active;
      pump_hi <= bias_hi;
      lock_n  <= !active;
    end
  end
endmodule

// File: rtl/phase_cmp_ld.sv
module phase_cmp_ld #(
  parameter int R_W      = 16,
  parameter int DEAD_CYC = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           ref_tick,
  input  logic           vco_pulse,
  input  logic [R_W-1:0] r_div,
  input  logic           pol_pos,
  input  logic           bias_hi,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           pump_oe,
  output logic           pump_hi,
  output logic           lock_n
);
  logic comp_tick;
  logic active;
  logic ref_ahead;

  ref_divider #(.R_W(R_W)) i_div (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .r_div     (r_div),
    .comp_tick (comp_tick)
  );

  edge_pair_core #(.DEAD_CYC(DEAD_CYC)) i_core (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .comp_tick (comp_tick),
    .vco_pulse (vco_pulse),
    .active    (active),
    .ref_ahead (ref_ahead)
  );

  pump_drive i_drv (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .ref_ahead (ref_ahead),
    .pol_pos   (pol_pos),
    .bias_hi   (bias_hi),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .pump_oe   (pump_oe),
    .pump_hi   (pump_hi),
    .lock_n    (lock_n)
  );
endmodule

// File: rtl/phase_cmp_ld_chk.sv
module phase_cmp_ld_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic pol_pos,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_oe,
  input logic lock_n
);
  assert_no_conflict_R5: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  assert_oe_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    pump_oe == (pump_up || pump_dn));

  assert_lock_width_R6: assert property (@(posedge clk) disable iff (rst)
    lock_n == !pump_oe);

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ##1 !pump_oe);

  assert_no_reversal_up_R4: assert property (@(posedge clk) disable iff (rst)
    (pump_up && $stable(pol_pos)) |-> !$past(pump_dn));

  assert_no_reversal_dn_R4: assert property (@(posedge clk) disable iff (rst)
    (pump_dn && $stable(pol_pos)) |-> !$past(pump_up));
endmodule

bind phase_cmp_ld phase_cmp_ld_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .pol_pos (pol_pos),
  .pump_up (pump_up),
  .pump_dn (pump_dn),
  .pump_oe (pump_oe),
  .lock_n  (lock_n)
);

// File: tb/test_phase_cmp_ld.sv
module test_phase_cmp_ld;
  localparam int R_W  = 16;
  localparam int DEAD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic ref_tick = 1'b0;
  logic vco_pulse = 1'b0;
  logic [R_W-1:0] r_div = 16'd1;
  logic pol_pos = 1'b1;
  logic bias_hi = 1'b0;
  logic pump_up, pump_dn, pump_oe, pump_hi, lock_n;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int n, up_cnt, dn_cnt, ld_cnt, first_on, both_cnt, oe_bad;

  always #2.5 clk = ~clk;

  phase_cmp_ld #(.R_W(R_W), .DEAD_CYC(DEAD)) i_phase_cmp_ld (
    .clk(clk), .rst(rst), .enable(enable), .ref_tick(ref_tick),
    .vco_pulse(vco_pulse), .r_div(r_div), .pol_pos(pol_pos),
    .bias_hi(bias_hi), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_oe(pump_oe), .pump_hi(pump_hi), .lock_n(lock_n)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n = 0; up_cnt = 0; dn_cnt = 0; ld_cnt = 0;
    first_on = -1; both_cnt = 0; oe_bad = 0;
  endtask

  // Sample outputs at the falling edge, then drive the next inputs.
  task automatic step(input logic rt, input logic vp, input logic en);
    @(negedge clk);
    if (pump_up) up_cnt++;
    if (pump_dn) dn_cnt++;
    if (!lock_n) ld_cnt++;
    if ((pump_up || pump_dn) && first_on < 0) first_on = n;
    if (pump_up && pump_dn) both_cnt++;
    if (pump_oe != (pump_up || pump_dn)) oe_bad++;
    ref_tick = rt; vco_pulse = vp; enable = en;
    n++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_tick = 0; vco_pulse = 0; enable = 1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 1);
  endtask

  // One event pair: e > 0 means the reference leads by e cycles.
  task automatic pair(input int e, input logic pol);
    int mag;
    int exp_w, exp_up, exp_dn;
    mag = (e < 0) ? -e : e;
    pol_pos = pol;
    idle(4);
    clear_counts();
    for (int k = 0; k <= mag; k++) begin
      logic rt, vp;
      rt = (e >= 0) ? (k == 0) : (k == mag);
      vp = (e >= 0) ? (k == mag) : (k == 0);
      step(rt, vp, 1);
    end
    idle(mag + DEAD + 10);
    exp_w  = (mag > DEAD) ? mag : 0;
    exp_up = ((e > 0) == pol) ? exp_w : 0;
    exp_dn = ((e > 0) == pol) ? 0 : exp_w;
    if (e == 0) begin exp_up = 0; exp_dn = 0; end
    if (mag > DEAD) begin
      check("R2 width", up_cnt + dn_cnt, exp_w);
      check("R4 up", up_cnt, exp_up);
      check("R4 dn", dn_cnt, exp_dn);
      check("R7 onset", first_on, DEAD + 3);
    end else begin
      check("R3 quiet", up_cnt + dn_cnt + ld_cnt, 0);
    end
    check("R6 lock width", ld_cnt, exp_w);
    check("R5 exclusive/oe", both_cnt + oe_bad, 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R11: reset state
    check("R11 up", pump_up, 0);
    check("R11 dn", pump_dn, 0);
    check("R11 oe", pump_oe, 0);
    check("R11 lock_n", lock_n, 1);
    check("R11 hi", pump_hi, 0);

    // R2, R3, R4, R5, R6, R7: offset sweep under both polarities
    for (int p = 0; p < 2; p++)
      for (int e = -8; e <= 8; e++)
        pair(e, logic'(p));

    // R1: divider ratio sweep; comparator cleared between ticks
    pol_pos = 1;
    for (int r = 0; r <= 5; r++) begin
      r_div = 16'(r);
      do_reset();
      for (int k = 1; k <= 8; k++) begin
        int rr;
        rr = (r == 0) ? 1 : r;
        clear_counts();
        step(1, 0, 1);
        idle(10);
        step(0, 0, 0);
        step(0, 0, 0);
        check($sformatf("R1 r=%0d tick=%0d", r, k), ld_cnt > 0, ((k - 1) % rr) == 0);
      end
    end
    r_div = 16'd1;
    do_reset();

    // R10: repeated leading strobe does not restart the window
    pol_pos = 1;
    idle(4);
    clear_counts();
    step(1, 0, 1); idle(2); step(1, 0, 1); idle(2); step(0, 1, 1);
    idle(20);
    check("R10 up width", up_cnt, 6);
    check("R10 dn", dn_cnt, 0);

    // R8: strobes ignored while disabled (divider still advances, R=1)
    clear_counts();
    step(0, 0, 0); step(1, 0, 0); idle(0);
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    step(0, 1, 0);
    for (int i = 0; i < 15; i++) step(0, 0, 0);
    check("R8 disabled quiet", up_cnt + dn_cnt + ld_cnt, 0);

    // R8: disabling mid-window stops output by the second edge
    idle(4);
    step(1, 0, 1);
    idle(8);
    check("R8 window open", pump_up, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    check("R8 cleared oe", pump_oe, 0);
    check("R8 cleared lock", lock_n, 1);
    do_reset();

    // R9: bias select follows one cycle later
    bias_hi = 1;
    @(negedge clk);
    check("R9 hi set", pump_hi, 1);
    bias_hi = 0;
    @(negedge clk);
    check("R9 hi clear", pump_hi, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule